// File: doc/BRIEF.md
# Serial Transceiver with Triple-Sample Noise Voting

This block is a full-duplex asynchronous serial port for talking to a host controller. A run-time divisor turns the system clock into a tick at sixteen times the line rate. A 100 MHz clock with a divisor near 108 gives 16 × 57 600 ticks per second. The transmitter takes one byte at a time over a valid/ready handshake. It sends a low start bit, the data bits least significant first, an optional parity bit and a high stop bit. Every bit lasts sixteen ticks.

The receiver finds a frame from the falling edge of the line. It then takes three samples of every bit on three consecutive ticks around the bit centre, and the bit's value is the majority of those samples. This covers the start bit, the data bits, the parity bit and the stop bit. If the three samples of any bit in a frame differ, the delivered byte carries a noise flag. It also carries parity and framing flags. When the start bit does not vote low, the receiver drops the frame and waits for the next edge.

Top module: `uart_vote_top`

## Requirements
- R1: The tick period is `baud_div`+1 clock cycles, and every bit on `txd`, from the start bit to the stop bit, lasts exactly 16 ticks.
- R2: `txd` rests high. A transmitted frame is one low bit, then the DATA_W data bits least significant first, then the parity bit when `par_en` is 1, then one high bit.
- R3: The transmitted parity bit is the XOR of the data bits when `par_odd` is 0, and the inverse of that XOR when `par_odd` is 1.
- R4: `tx_ready` is 1 only while the transmitter is idle. A byte is taken on a clock edge where `tx_valid` and `tx_ready` are both 1. `tx_ready` is 0 from the next cycle until the stop bit has finished, and is 1 again in the cycle after the stop bit ends.
- R5: The receiver samples each bit on ticks 7, 8 and 9 of the 16 ticks in that bit, counted from the detected falling edge. The received value of the bit is the majority of the three samples.
- R6: `rx_nerr` is 1 for a frame if the three samples of any of its bits differ, start and stop bits included. The data is still taken from the majority vote.
- R7: A falling edge whose start bit votes high is dropped. No `rx_valid` follows it, and the next frame is received normally.
- R8: A stop bit that votes low sets `rx_ferr` for that frame, and the frame is still delivered.
- R9: With `par_en` at 1, `rx_perr` is 1 when the received parity bit differs from the parity that R3 gives for the received data. With `par_en` at 0, no parity bit is expected and `rx_perr` is 0.
- R10: `rx_valid` is a single-cycle pulse. `rx_data` and the three flags change only on that pulse and hold their values until the next one.
- R11: While reset is applied and in the first cycle after it, `txd`=1, `tx_ready`=1, `rx_valid`=0, `rx_data`=0 and all error flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| baud_div | input | DIV_W | Tick period minus one, in clock cycles |
| par_en | input | 1 | 1 adds a parity bit to each frame |
| par_odd | input | 1 | 1 selects odd parity, 0 even |
| tx_data | input | DATA_W | Byte to send |
| tx_valid | input | 1 | Byte on tx_data is offered |
| tx_ready | output | 1 | Transmitter idle, can take a byte |
| txd | output | 1 | Serial output line |
| rxd | input | 1 | Serial input line, asynchronous |
| rx_data | output | DATA_W | Last received byte |
| rx_valid | output | 1 | One-cycle pulse when a frame completes |
| rx_perr | output | 1 | Parity mismatch in the last frame |
| rx_ferr | output | 1 | Low stop bit in the last frame |
| rx_nerr | output | 1 | Sample disagreement in the last frame |

## Verification
The bench uses the default parameters: eight data bits, a 16-bit divisor and 16 ticks per bit. It changes `baud_div` between 0, 3 and 6. That gives bit periods of 16, 64 and 112 cycles, short enough for many whole frames. Divisor 0 puts a tick on every cycle, and the other two check that bit width scales with the divisor. With a tick period of P cycles, the bench can place a line glitch of exactly P cycles on one sample of a bit, or a glitch of 2P cycles on two samples. This lets it flip one vote without changing the majority, or flip the majority itself, in the start, data, parity and stop bits.

// File: rtl/uart_vote_pkg.sv
// Shared types and helpers for the serial transceiver.
// Assumes: three-sample voting on an odd number of samples.
package uart_vote_pkg;

    localparam int OVERSAMPLE = 16;

    typedef enum logic [2:0] {
        TX_IDLE, TX_WAIT, TX_START, TX_DATA, TX_PAR, TX_STOP
    } tx_state_t;

    typedef enum logic [2:0] {
        RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP
    } rx_state_t;

    // Majority of three samples.
    function automatic logic vote3(input logic [2:0] s);
        return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
    endfunction

    // True when the three samples are not all the same.
    function automatic logic split3(input logic [2:0] s);
        return (s != 3'b000) && (s != 3'b111);
    endfunction

endpackage

// File: rtl/uart_vote_tick.sv
// Oversampling tick generator: one-cycle tick every baud_div+1 clocks.
// Assumes: baud_div changes only while both directions are idle;
// a shrinking divisor is handled by wrapping on >=.
module uart_vote_tick #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] baud_div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt;

    assign tick = (cnt >= baud_div);

    // Count clock cycles and wrap at the divisor.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (tick)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/uart_vote_tx.sv
// Transmitter: serialises one byte per handshake as start, data LSB
// first, optional parity, stop. The start bit is aligned to a tick so
// that every bit spans exactly OSR ticks.
// Assumes: par_en and par_odd are captured when the byte is accepted.
module uart_vote_tx
    import uart_vote_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OSR    = OVERSAMPLE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic              txd
);

    localparam int PH_W = $clog2(OSR);
    localparam int BC_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(OSR - 1);
    localparam logic [BC_W-1:0] BC_LAST = BC_W'(DATA_W - 1);

    tx_state_t         state;
    logic [PH_W-1:0]   ph;
    logic [BC_W-1:0]   bc;
    logic [DATA_W-1:0] shreg;
    logic              par_bit;
    logic              par_on;
    logic              txd_r;

    assign tx_ready = (state == TX_IDLE);
    assign txd      = txd_r;

    // Frame sequencer: accept, align to tick, then shift bits out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= TX_IDLE;
            ph      <= '0;
            bc      <= '0;
            shreg   <= '0;
            par_bit <= 1'b0;
            par_on  <= 1'b0;
            txd_r   <= 1'b1;
        end else begin
            case (state)
                TX_IDLE: begin
                    if (tx_valid) begin
                        shreg   <= tx_data;
                        par_bit <= (^tx_data) ^ par_odd;
                        par_on  <= par_en;
                        state   <= TX_WAIT;
                    end
                end
                TX_WAIT: begin
                    if (tick) begin
                        txd_r <= 1'b0;
                        ph    <= '0;
                        state <= TX_START;
                    end
                end
                default: begin
                    if (tick) begin
                        if (ph != PH_LAST) begin
                            ph <= ph + 1'b1;
                        end else begin
                            ph <= '0;
                            case (state)
                                TX_START: begin
                                    txd_r <= shreg[0];
                                    shreg <= shreg >> 1;
                                    bc    <= '0;
                                    state <= TX_DATA;
                                end
                                TX_DATA: begin
                                    if (bc != BC_LAST) begin
                                        bc    <= bc + 1'b1;
                                        txd_r <= shreg[0];
                                        shreg <= shreg >> 1;
                                    end else if (par_on) begin
                                        txd_r <= par_bit;
                                        state <= TX_PAR;
                                    end else begin
                                        txd_r <= 1'b1;
                                        state <= TX_STOP;
                                    end
                                end
                                TX_PAR: begin
                                    txd_r <= 1'b1;
                                    state <= TX_STOP;
                                end
                                default: begin
                                    state <= TX_IDLE;
                                end
                            endcase
                        end
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/uart_vote_rx.sv
// Receiver: synchronises the line, starts on a falling edge, takes
// three samples per bit on ticks OSR/2-1, OSR/2 and OSR/2+1, and uses
// the majority. Any disagreement in a frame sets the noise flag.
// Assumes: DATA_W >= 2, OSR >= 4, par_en and par_odd are stable
// during a frame.
module uart_vote_rx
    import uart_vote_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OSR    = OVERSAMPLE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              rxd,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              rx_perr,
    output logic              rx_ferr,
    output logic              rx_nerr
);

    localparam int PH_W = $clog2(OSR);
    localparam int BC_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam int CTR  = OSR / 2;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(OSR - 1);
    localparam logic [PH_W-1:0] PH_S0   = PH_W'(CTR - 1);
    localparam logic [PH_W-1:0] PH_S1   = PH_W'(CTR);
    localparam logic [PH_W-1:0] PH_S2   = PH_W'(CTR + 1);
    localparam logic [BC_W-1:0] BC_LAST = BC_W'(DATA_W - 1);

    rx_state_t         state;
    logic              sync_a, rxd_s, rxd_q;
    logic [PH_W-1:0]   ph;
    logic [BC_W-1:0]   bc;
    logic [DATA_W-1:0] shreg;
    logic [1:0]        samp;
    logic              noise;
    logic              par_rx;
    logic [2:0]        trio;
    logic              bit_v;
    logic              bit_split;

    // Vote over the two stored samples and the current line value.
    always_comb begin
        trio      = {samp[1], samp[0], rxd_s};
        bit_v     = vote3(trio);
        bit_split = split3(trio);
    end

    // Line synchroniser, frame sequencer and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_a   <= 1'b1;
            rxd_s    <= 1'b1;
            rxd_q    <= 1'b1;
            state    <= RX_IDLE;
            ph       <= '0;
            bc       <= '0;
            shreg    <= '0;
            samp     <= '0;
            noise    <= 1'b0;
            par_rx   <= 1'b0;
            rx_valid <= 1'b0;
            rx_data  <= '0;
            rx_perr  <= 1'b0;
            rx_ferr  <= 1'b0;
            rx_nerr  <= 1'b0;
        end else begin
            sync_a   <= rxd;
            rxd_s    <= sync_a;
            rxd_q    <= rxd_s;
            rx_valid <= 1'b0;
            if (state == RX_IDLE) begin
                if (rxd_q && !rxd_s) begin
                    state <= RX_START;
                    ph    <= '0;
                    noise <= 1'b0;
                end
            end else if (tick) begin
                if (ph == PH_S0) samp[0] <= rxd_s;
                if (ph == PH_S1) samp[1] <= rxd_s;
                if (ph == PH_LAST) ph <= '0;
                else               ph <= ph + 1'b1;
                if (ph == PH_S2) begin
                    case (state)
                        RX_START: begin
                            if (bit_v) state <= RX_IDLE;
                            else       noise <= bit_split;
                        end
                        RX_DATA: begin
                            shreg <= {bit_v, shreg[DATA_W-1:1]};
                            noise <= noise | bit_split;
                        end
                        RX_PAR: begin
                            par_rx <= bit_v;
                            noise  <= noise | bit_split;
                        end
                        default: begin
                            rx_valid <= 1'b1;
                            rx_data  <= shreg;
                            rx_ferr  <= ~bit_v;
                            rx_nerr  <= noise | bit_split;
                            rx_perr  <= par_en & (par_rx != ((^shreg) ^ par_odd));
                            state    <= RX_IDLE;
                        end
                    endcase
                end
                if (ph == PH_LAST) begin
                    case (state)
                        RX_START: begin
                            bc    <= '0;
                            state <= RX_DATA;
                        end
                        RX_DATA: begin
                            if (bc != BC_LAST) bc <= bc + 1'b1;
                            else               state <= par_en ? RX_PAR : RX_STOP;
                        end
                        RX_PAR: state <= RX_STOP;
                        default: ;
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/uart_vote_top.sv
// Full-duplex serial transceiver with three-sample noise voting.
// Assumes: one shared tick drives both directions; rxd is asynchronous.
module uart_vote_top
    import uart_vote_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 16,
    parameter int OSR    = OVERSAMPLE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  baud_div,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic              txd,
    input  logic              rxd,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              rx_perr,
    output logic              rx_ferr,
    output logic              rx_nerr
);

    logic baud_tick;

    uart_vote_tick #(.DIV_W(DIV_W)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .baud_div (baud_div),
        .tick     (baud_tick)
    );

    uart_vote_tx #(.DATA_W(DATA_W), .OSR(OSR)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (baud_tick),
        .par_en   (par_en),
        .par_odd  (par_odd),
        .tx_data  (tx_data),
        .tx_valid (tx_valid),
        .tx_ready (tx_ready),
        .txd      (txd)
    );

    uart_vote_rx #(.DATA_W(DATA_W), .OSR(OSR)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (baud_tick),
        .par_en   (par_en),
        .par_odd  (par_odd),
        .rxd      (rxd),
        .rx_data  (rx_data),
        .rx_valid (rx_valid),
        .rx_perr  (rx_perr),
        .rx_ferr  (rx_ferr),
        .rx_nerr  (rx_nerr)
    );

endmodule

// File: rtl/uart_vote_chk.sv
// Property checker for the transceiver, attached by bind.
// Assumes: sees the top ports and the internal tick.
module uart_vote_chk #(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DIV_W-1:0]  baud_div,
    input logic              baud_tick,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic              txd,
    input logic [DATA_W-1:0] rx_data,
    input logic              rx_valid,
    input logic              rx_perr,
    input logic              rx_ferr,
    input logic              rx_nerr
);

    logic seen;

    // Marks that one clean cycle after reset has passed.
    always_ff @(posedge clk) begin
        if (!rst_n) seen <= 1'b0;
        else        seen <= 1'b1;
    end

    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        (baud_tick && baud_div != '0) |=> !baud_tick); // R1

    AST_TXD_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && !baud_tick) |=> $stable(txd)); // R1

    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> txd); // R2

    AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> !tx_ready); // R4

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid); // R10

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && !rx_valid) |-> ($stable(rx_data) && $stable(rx_perr)
                                 && $stable(rx_ferr) && $stable(rx_nerr))); // R10

endmodule

bind uart_vote_top uart_vote_chk #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .baud_div  (baud_div),
    .baud_tick (baud_tick),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .txd       (txd),
    .rx_data   (rx_data),
    .rx_valid  (rx_valid),
    .rx_perr   (rx_perr),
    .rx_ferr   (rx_ferr),
    .rx_nerr   (rx_nerr)
);

// File: tb/sim_uart_vote_top.sv
`timescale 1ns/1ps
module sim_uart_vote_top;

    localparam int DW = 8;
    localparam int VW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [VW-1:0] baud_div;
    logic          par_en, par_odd;
    logic [DW-1:0] tx_data;
    logic          tx_valid;
    logic          tx_ready, txd;
    logic          rxd;
    logic [DW-1:0] rx_data;
    logic          rx_valid, rx_perr, rx_ferr, rx_nerr;

    int  n_chk = 0;
    int  n_fail = 0;
    int  per = 4;
    bit  done = 0;

    uart_vote_top u0 (
        .clk(clk), .rst_n(rst_n), .baud_div(baud_div),
        .par_en(par_en), .par_odd(par_odd),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .txd(txd),
        .rxd(rxd), .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_nerr(rx_nerr)
    );

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // Parity from a count of ones.
    function automatic logic par_of(input logic [DW-1:0] d, input logic odd);
        int ones = 0;
        for (int i = 0; i < DW; i++) if (d[i]) ones++;
        return ((ones % 2) == 1) ^ odd;
    endfunction

    // ---------------- transmit reference model ----------------
    logic [15:0] txq_bits[$];
    int          txq_len[$];
    bit          in_fr = 0;
    bit          post = 0;
    int          k, fr_len, fr_per;
    logic [15:0] fr_bits;

    always @(negedge clk) begin
        if (rst_n) begin
            if (post) begin
                chk(tx_ready === 1'b1, "R4 ready again after stop", tx_ready, 1);
                post = 0;
            end
            if (!in_fr && txd === 1'b0) begin
                if (txq_len.size() == 0) begin
                    chk(0, "R2 start without accepted byte", txd, 1);
                end else begin
                    fr_bits = txq_bits.pop_front();
                    fr_len  = txq_len.pop_front();
                    fr_per  = per;
                    in_fr   = 1;
                    k       = 0;
                end
            end
            if (in_fr) begin
                chk(txd === fr_bits[k / (16 * fr_per)], "R1 R2 R3 txd level",
                    txd, fr_bits[k / (16 * fr_per)]);
                k++;
                if (k == fr_len * 16 * fr_per) begin
                    in_fr = 0;
                    post  = 1;
                end
            end
        end
    end

    task automatic send_tx(input logic [DW-1:0] d);
        logic [15:0] b = '1;
        b[0] = 1'b0;
        for (int i = 0; i < DW; i++) b[1 + i] = d[i];
        if (par_en) b[1 + DW] = par_of(d, par_odd);
        txq_bits.push_back(b);
        txq_len.push_back(DW + 2 + (par_en ? 1 : 0));
        @(negedge clk);
        tx_data  = d;
        tx_valid = 1'b1;
        while (!tx_ready) @(negedge clk);
        @(negedge clk);
        tx_valid = 1'b0;
        chk(tx_ready == 1'b0, "R4 ready low after accept", tx_ready, 0);
    endtask

    task automatic wait_tx_done();
        while (in_fr || txq_len.size() != 0 || !tx_ready) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    // ---------------- receive reference model ----------------
    logic [DW+2:0] rxq[$];
    logic [DW-1:0] last_rx = '0;

    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            if (rxq.size() == 0) begin
                chk(0, "R7 rx_valid with no frame expected", 1, 0);
            end else begin
                logic [DW+2:0] e;
                e = rxq.pop_front();
                chk(rx_data == e[DW-1:0], "R5 received data", rx_data, e[DW-1:0]);
                chk(rx_perr == e[DW],     "R9 parity flag",  rx_perr, e[DW]);
                chk(rx_ferr == e[DW+1],   "R8 framing flag", rx_ferr, e[DW+1]);
                chk(rx_nerr == e[DW+2],   "R6 noise flag",   rx_nerr, e[DW+2]);
                last_rx = e[DW-1:0];
            end
        end
    end

    // Drive one frame on rxd; gl_bit selects a bit to glitch (-1: none),
    // gl_len of per cycles flips one sample, 2*per flips two.
    task automatic send_rx(input logic [DW-1:0] d, input bit bad_par, input bit stop_lvl,
                           input int gl_bit, input int gl_len);
        logic [15:0]   b = '1;
        logic [DW-1:0] ed;
        int            n, gs;
        bit            ep;
        b[0] = 1'b0;
        for (int i = 0; i < DW; i++) b[1 + i] = d[i];
        n = DW + 2;
        if (par_en) begin
            b[1 + DW] = par_of(d, par_odd) ^ bad_par;
            n++;
        end
        b[n - 1] = stop_lvl;
        ed = d;
        if (gl_len >= 2 * per && gl_bit >= 1 && gl_bit <= DW) ed[gl_bit - 1] = ~ed[gl_bit - 1];
        ep = par_en && (b[1 + DW] != par_of(ed, par_odd));
        rxq.push_back({(gl_bit >= 0 && gl_len > 0), ~stop_lvl, ep, ed});
        gs = (gl_len >= 2 * per) ? 7 * per + 1 : 8 * per + 1;
        for (int i = 0; i < n; i++) begin
            for (int c = 0; c < 16 * per; c++) begin
                @(negedge clk);
                rxd = b[i] ^ ((i == gl_bit) && (c >= gs) && (c < gs + gl_len));
            end
        end
        @(negedge clk);
        rxd = 1'b1;
        repeat (16 * per) @(negedge clk);
    endtask

    task automatic set_div(input int v);
        baud_div = VW'(v);
        per = v + 1;
        repeat (3) @(negedge clk);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            report();
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        baud_div = VW'(3);
        par_en   = 1'b1;
        par_odd  = 1'b0;
        tx_data  = '0;
        tx_valid = 1'b0;
        rxd      = 1'b1;
        repeat (5) @(negedge clk);
        chk(txd == 1'b1,      "R11 txd at reset",      txd, 1);
        chk(tx_ready == 1'b1, "R11 ready at reset",    tx_ready, 1);
        chk(rx_valid == 1'b0, "R11 valid at reset",    rx_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rx_data == '0,    "R11 data after reset",  rx_data, 0);
        chk({rx_perr, rx_ferr, rx_nerr} == 3'b000, "R11 flags after reset",
            {rx_perr, rx_ferr, rx_nerr}, 0);
        chk(txd == 1'b1 && tx_ready == 1'b1, "R11 idle line after reset", {txd, tx_ready}, 3);

        set_div(3);
        // Even parity, clean frames both ways (R2 R3 R5)
        send_tx(8'hA5);
        wait_tx_done();
        send_rx(8'hA5, 0, 1, -1, 0);
        // Odd parity (R3)
        par_odd = 1'b1;
        send_tx(8'h3C);
        wait_tx_done();
        send_rx(8'h3C, 0, 1, -1, 0);
        // No parity bit (R9)
        par_en = 1'b0;
        send_tx(8'h81);
        wait_tx_done();
        send_rx(8'h7E, 0, 1, -1, 0);
        // Hold after frame (R10)
        repeat (40) @(negedge clk);
        chk(rx_data == 8'h7E && !rx_valid, "R10 result held", rx_data, 8'h7E);
        // Parity mismatch (R9)
        par_en  = 1'b1;
        par_odd = 1'b0;
        send_rx(8'h5A, 1, 1, -1, 0);
        // Low stop bit (R8)
        send_rx(8'hC3, 0, 0, -1, 0);
        repeat (20) @(negedge clk);
        // Single-sample glitches: start, data, parity, stop (R6)
        send_rx(8'h96, 0, 1, 0, per);
        send_rx(8'h96, 0, 1, 5, per);
        send_rx(8'h0F, 0, 1, DW + 1, per);
        send_rx(8'hF0, 0, 1, DW + 2, per);
        // Two-sample glitch flips data bit 3 by majority (R5 R6)
        send_rx(8'h24, 0, 1, 4, 2 * per);
        // False start: short low pulse, then a clean frame (R7)
        @(negedge clk);
        rxd = 1'b0;
        repeat (per) @(negedge clk);
        rxd = 1'b1;
        repeat (24 * per) @(negedge clk);
        chk(rxq.size() == 0, "R7 no frame from false start", rxq.size(), 0);
        send_rx(8'h11, 0, 1, -1, 0);

        // Slower tick, full duplex (R1)
        set_div(6);
        fork
            send_tx(8'h6B);
            send_rx(8'hE2, 0, 1, 3, per);
        join
        wait_tx_done();

        // Tick every cycle (R1)
        set_div(0);
        par_odd = 1'b1;
        send_tx(8'hFF);
        wait_tx_done();
        send_rx(8'h00, 0, 1, -1, 0);
        send_rx(8'h9D, 0, 1, 2, 2 * per);

        repeat (40) @(negedge clk);
        chk(rxq.size() == 0, "R10 every expected frame delivered", rxq.size(), 0);
        chk(rx_data == last_rx && !rx_valid, "R10 last result held", rx_data, last_rx);
        done = 1;
        report();
        $finish;
    end

endmodule